// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Timer

This block drives a single output pulse whose width is a programmed number of count-source ticks. The count source comes in as a one-cycle enable strobe, `tick`, made by a prescaler outside the block. A trigger comes from one of two places. Software can write a command bit, or an edge on an external pin can start it. The external edge passes through a synchroniser, and its polarity is a setting. The output rises on the next tick. A down-counter loaded from the reload register then times the pulse. When the counter runs out, the output falls, the counter reloads and an interrupt request flag is set.

A trigger that arrives while a pulse is running extends the pulse. The counter decrements once more and then reloads, and the output stays high. A trigger taken at the tick right after an accepted trigger is discarded. Clearing the start bit ends the pulse at once and reloads the counter. The interrupt flag rises one clock later. Configuration writes are refused while the timer runs. A cutoff input can switch the output driver off.

Register map (write port, `wr_addr`):
- 0: control. Bit 0 is the start bit.
- 1: configuration. Bits 1:0 select the mode: 0 timer, 1 event counter, 2 one-shot, 3 reserved. Bit 2 selects the trigger source: 0 software, 1 external pin. Bit 3 selects the edge: 0 rising, 1 falling. Bit 4 enables cutoff.
- 2: reload value.
- 3: command. Bit 0 is the software trigger. Bit 1 clears the interrupt flag.

Top module: `oneshot_pulse_timer`

## Requirements
- R1: After reset, `pulse_out`, `irq`, `count` and `cfg_rd` are 0. While the start bit is 0, nothing changes `count`, not ticks and not triggers.
- R2: Writes to address 1 update `cfg_rd` only while the start bit is 0. While the timer runs they are ignored.
- R3: Writing 0 to the start bit while it is 1 does three things on the next clock edge: it drives `pulse_out` low, loads `count` from the reload register, and drops any pending trigger.
- R4: After a stop as in R3, `irq` rises one clock later than the edge that applied the stop.
- R5: `pulse_out` changes only on a `tick` cycle or on a stop. An external edge of the selected polarity reaches the timer through a 2-flop synchroniser and an edge detector. An edge of the other polarity is ignored.
- R6: A configuration write that selects mode 2 while the current mode is not 2 sets `irq`. Writing bit 1 of address 3 clears `irq`. When a set and a clear come together, the set wins.
- R7: A trigger taken on a tick while idle raises `pulse_out` and loads `count` with the reload value N (N > 0). Each later tick decrements `count`. On the tick where `count` is 1, `pulse_out` falls, `count` reloads and `irq` is set, so the pulse lasts N ticks.
- R8: A trigger taken on a tick while the pulse runs decrements `count` once and keeps `pulse_out` high. On the next tick `count` reloads.
- R9: A trigger that would be taken on the tick right after an accepted trigger is discarded.
- R10: With reload value 0, a trigger taken while idle leaves `pulse_out` low and sets `irq`.
- R11: `pulse_oe` is 0 exactly when configuration bit 4 is 1 and `cut_n` is low.
- R12: A trigger is armed only when the start bit is 1 and the mode is 2. It is taken only from the selected source. A software trigger is ignored when the external pin is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count-source enable strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | CNT_W | Register write data |
| trig_pin | input | 1 | Asynchronous external trigger pin |
| cut_n | input | 1 | Active-low output cutoff input |
| pulse_out | output | 1 | Pulse output value |
| pulse_oe | output | 1 | Output driver enable (0 = high impedance) |
| irq | output | 1 | Interrupt request flag |
| count | output | CNT_W | Current counter value |
| cfg_rd | output | 5 | Current configuration register |

## Verification
The bench builds the block with CNT_W = 8 and SYNC_STAGES = 2. The narrow counter keeps full pulses short, so random reload values from 0 to 9 complete many whole pulses. It also leaves room for retriggers, the discard window and zero-reload triggers between them. A tick-level model in the bench follows every tick. The default synchroniser depth makes the external-edge delay small and fixed, so directed tests can show that the output waits for a tick and that an edge of the wrong polarity is ignored.

// File: rtl/ost_pkg.sv
package ost_pkg;
  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_CFG    = 2'd1;
  localparam logic [1:0] ADDR_RELOAD = 2'd2;
  localparam logic [1:0] ADDR_CMD    = 2'd3;

  typedef enum logic [1:0] {
    MODE_TIMER   = 2'd0,
    MODE_EVENT   = 2'd1,
    MODE_ONESHOT = 2'd2,
    MODE_RSVD    = 2'd3
  } mode_e;

  typedef struct packed {
    logic  cut_en;
    logic  edge_fall;
    logic  trig_ext;
    mode_e mode;
  } cfg_t;
endpackage

// File: rtl/ost_trig_sync.sv
module ost_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic fall_sel,
  output logic edge_o
);
  localparam int LAST = STAGES;

  logic [LAST:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[LAST-1:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // sh_q[LAST-1] is the settled sample, sh_q[LAST] the previous one
  always_comb begin
    if (fall_sel) edge_o = sh_q[LAST] & ~sh_q[LAST-1];
    else          edge_o = sh_q[LAST-1] & ~sh_q[LAST];
  end
endmodule

// File: rtl/ost_regs.sv
module ost_regs
  import ost_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             irq_set_core,
  output logic             start_q,
  output cfg_t             cfg_q,
  output logic [CNT_W-1:0] reload_q,
  output logic             sw_trig,
  output logic             stop_ev,
  output logic             irq_q
);
  logic             start_d, stop_dly_q, stop_dly_d, irq_d;
  cfg_t             cfg_d;
  logic [CNT_W-1:0] reload_d;
  logic             wr_ctrl, wr_cfg, wr_rl, wr_cmd, mode_irq, irq_clr;

  always_comb begin
    wr_ctrl  = wr_en && (wr_addr == ADDR_CTRL);
    wr_cfg   = wr_en && (wr_addr == ADDR_CFG) && !start_q;
    wr_rl    = wr_en && (wr_addr == ADDR_RELOAD);
    wr_cmd   = wr_en && (wr_addr == ADDR_CMD);
    start_d  = wr_ctrl ? wr_data[0] : start_q;
    stop_ev  = wr_ctrl && start_q && !wr_data[0];
    cfg_d    = wr_cfg ? cfg_t'(wr_data[4:0]) : cfg_q;
    mode_irq = wr_cfg && (wr_data[1:0] == MODE_ONESHOT) && (cfg_q.mode != MODE_ONESHOT);
    reload_d = wr_rl ? wr_data : reload_q;
    sw_trig  = wr_cmd && wr_data[0];
    irq_clr  = wr_cmd && wr_data[1];
    stop_dly_d = stop_ev;
    if (irq_set_core || mode_irq || stop_dly_q) irq_d = 1'b1;
    else if (irq_clr)                           irq_d = 1'b0;
    else                                        irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q    <= 1'b0;
      cfg_q      <= '0;
      reload_q   <= '0;
      stop_dly_q <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      start_q    <= start_d;
      cfg_q      <= cfg_d;
      reload_q   <= reload_d;
      stop_dly_q <= stop_dly_d;
      irq_q      <= irq_d;
    end
  end
endmodule

// File: rtl/ost_core.sv
module ost_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             armed,
  input  logic             trig_evt,
  input  logic             stop_ev,
  input  logic [CNT_W-1:0] reload,
  output logic             out_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             irq_set
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             out_d, pend_q, pend_d, guard_q, guard_d, due_q, due_d, take;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    out_d   = out_q;
    cnt_d   = cnt_q;
    pend_d  = pend_q;
    guard_d = guard_q;
    due_d   = due_q;
    irq_set = 1'b0;
    take    = armed && (pend_q || trig_evt);
    if (stop_ev) begin
      out_d   = 1'b0;
      cnt_d   = reload;
      pend_d  = 1'b0;
      guard_d = 1'b0;
      due_d   = 1'b0;
    end else if (tick) begin
      pend_d  = 1'b0;
      guard_d = 1'b0;
      if (take && !guard_q) begin
        guard_d = 1'b1;
        if (!out_q) begin
          if (reload == '0) irq_set = 1'b1;
          else begin
            out_d = 1'b1;
            cnt_d = reload;
          end
        end else begin
          cnt_d = cnt_q - ONE;
          due_d = 1'b1;
        end
      end else if (out_q) begin
        if (due_q) begin
          cnt_d = reload;
          due_d = 1'b0;
        end else if (cnt_q <= ONE) begin
          out_d   = 1'b0;
          cnt_d   = reload;
          irq_set = 1'b1;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
    end else if (armed && trig_evt) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= 1'b0;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      guard_q <= 1'b0;
      due_q   <= 1'b0;
    end else begin
      out_q   <= out_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
      guard_q <= guard_d;
      due_q   <= due_d;
    end
  end
endmodule

// File: rtl/oneshot_pulse_timer.sv
module oneshot_pulse_timer
  import ost_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             trig_pin,
  input  logic             cut_n,
  output logic             pulse_out,
  output logic             pulse_oe,
  output logic             irq,
  output logic [CNT_W-1:0] count,
  output logic [4:0]       cfg_rd
);
  logic             start_q, sw_trig, stop_ev, irq_set, ext_edge, armed, trig_evt;
  cfg_t             cfg_q;
  logic [CNT_W-1:0] reload_q;

  ost_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_set_core(irq_set), .start_q(start_q), .cfg_q(cfg_q), .reload_q(reload_q),
    .sw_trig(sw_trig), .stop_ev(stop_ev), .irq_q(irq)
  );

  ost_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(trig_pin), .fall_sel(cfg_q.edge_fall), .edge_o(ext_edge)
  );

  always_comb begin
    armed    = start_q && (cfg_q.mode == MODE_ONESHOT);
    trig_evt = cfg_q.trig_ext ? ext_edge : sw_trig;
  end

  ost_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .armed(armed), .trig_evt(trig_evt),
    .stop_ev(stop_ev), .reload(reload_q), .out_q(pulse_out), .cnt_q(count),
    .irq_set(irq_set)
  );

  always_comb begin
    pulse_oe = !(cfg_q.cut_en && !cut_n);
    cfg_rd   = cfg_q;
  end
endmodule

// File: rtl/ost_checker.sv
module ost_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             start_q,
  input logic [4:0]       cfg_q,
  input logic             stop_ev,
  input logic             irq,
  input logic             pulse_out,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] reload
);
  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !start_q |=> $stable(cnt));

  assert_cfg_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> $stable(cfg_q));

  assert_stop_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (!pulse_out && cnt == $past(reload)));

  assert_stop_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> ##1 irq);

  assert_tick_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !stop_ev) |=> $stable(pulse_out));

  assert_end_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pulse_out) && !$past(stop_ev)) |-> irq);
endmodule

bind oneshot_pulse_timer ost_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .start_q(start_q), .cfg_q(cfg_q),
  .stop_ev(stop_ev), .irq(irq), .pulse_out(pulse_out), .cnt(count), .reload(reload_q)
);

// File: tb/oneshot_pulse_timer_test.sv
`timescale 1ns/1ps
module oneshot_pulse_timer_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic         trig_pin = 1'b0;
  logic         cut_n = 1'b1;
  logic         pulse_out, pulse_oe, irq;
  logic [W-1:0] count;
  logic [4:0]   cfg_rd;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // tick-level model
  bit           m_out, m_due, m_guard, m_irq;
  logic [W-1:0] m_cnt, m_rl;

  oneshot_pulse_timer #(.CNT_W(W), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .trig_pin(trig_pin), .cut_n(cut_n), .pulse_out(pulse_out),
    .pulse_oe(pulse_oe), .irq(irq), .count(count), .cfg_rd(cfg_rd)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick_once();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic m_tick(input bit trig);
    bit g;
    g = m_guard;
    m_guard = 0;
    if (trig && !g) begin
      m_guard = 1;
      if (!m_out) begin
        if (m_rl == 0) m_irq = 1;
        else begin m_out = 1; m_cnt = m_rl; end
      end else begin
        m_cnt = m_cnt - 1; m_due = 1;
      end
    end else if (m_out) begin
      if (m_due) begin m_cnt = m_rl; m_due = 0; end
      else if (m_cnt <= 1) begin m_out = 0; m_cnt = m_rl; m_irq = 1; end
      else m_cnt = m_cnt - 1;
    end
  endtask

  task automatic cmp(input string tag);
    check({tag, " out"}, 32'(pulse_out), 32'(m_out));
    check({tag, " cnt"}, 32'(count), 32'(m_cnt));
    check({tag, " irq"}, 32'(irq), 32'(m_irq));
  endtask

  // sw trigger (optional) then one tick, compared with the model
  task automatic step(input bit trig, input string tag);
    if (trig) wr(2'd3, 8'h01);
    tick_once();
    m_tick(trig);
    cmp(tag);
  endtask

  task automatic clr_irq();
    wr(2'd3, 8'h02);
    m_irq = 0;
  endtask

  task automatic set_reload(input logic [W-1:0] v);
    wr(2'd2, v);
    m_rl = v;
  endtask

  task automatic stop_check();
    clr_irq();
    wr(2'd0, 8'h00);
    m_out = 0; m_cnt = m_rl; m_due = 0; m_guard = 0;
    check("R3 stop out", 32'(pulse_out), 32'd0);
    check("R3 stop cnt", 32'(count), 32'(m_rl));
    check("R4 irq not yet", 32'(irq), 32'd0);
    @(negedge clk);
    check("R4 irq after one clock", 32'(irq), 32'd1);
    m_irq = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    m_out = 0; m_due = 0; m_guard = 0; m_irq = 0; m_cnt = '0; m_rl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 out", 32'(pulse_out), 32'd0);
    check("R1 irq", 32'(irq), 32'd0);
    check("R1 cnt", 32'(count), 32'd0);
    check("R1 cfg", 32'(cfg_rd), 32'd0);
    // R1/R12 idle: triggers and ticks with start 0 do nothing
    set_reload(8'd4);
    wr(2'd3, 8'h01);
    tick_once(); tick_once();
    check("R1 idle cnt", 32'(count), 32'd0);
    check("R12 unarmed out", 32'(pulse_out), 32'd0);

    // R6 mode selection flag
    wr(2'd1, 8'h02);
    check("R6 oneshot select irq", 32'(irq), 32'd1);
    clr_irq();
    check("R6 irq cleared", 32'(irq), 32'd0);
    wr(2'd1, 8'h01);
    check("R6 event mode no irq", 32'(irq), 32'd0);
    wr(2'd1, 8'h02);
    check("R6 event->oneshot irq", 32'(irq), 32'd1);
    wr(2'd1, 8'h02);
    clr_irq();
    wr(2'd1, 8'h02);
    check("R6 oneshot->oneshot no irq", 32'(irq), 32'd0);

    // R7 basic pulse, reload 5
    set_reload(8'd5);
    wr(2'd0, 8'h01);
    step(1, "R7 start");
    for (int i = 0; i < 5; i++) step(0, "R7 run");
    check("R7 ended low", 32'(pulse_out), 32'd0);
    check("R7 end irq", 32'(irq), 32'd1);
    clr_irq();

    // R2 write protection while running
    wr(2'd1, 8'h16);
    check("R2 cfg ignored while running", 32'(cfg_rd), 32'h02);

    // R8 retrigger and R9 discard window
    step(1, "R8 start");
    step(0, "R8 run");
    step(1, "R8 retrigger");
    check("R8 stays high", 32'(pulse_out), 32'd1);
    step(1, "R9 early trigger discarded");
    step(0, "R8 after reload");
    step(0, "R8 run");

    // R3/R4 stop while running
    stop_check();

    // R10 zero reload
    set_reload(8'd0);
    wr(2'd0, 8'h01);
    clr_irq();
    step(1, "R10 zero reload");
    check("R10 no pulse", 32'(pulse_out), 32'd0);
    check("R10 irq", 32'(irq), 32'd1);
    stop_check();

    // R2 accepted while stopped; R5 external rising edge
    set_reload(8'd3);
    wr(2'd1, 8'h06);
    check("R2 cfg accepted while stopped", 32'(cfg_rd), 32'h06);
    wr(2'd0, 8'h01);
    clr_irq();
    @(negedge clk); trig_pin = 1'b1;
    repeat (5) @(negedge clk);
    check("R5 no tick no change", 32'(pulse_out), 32'd0);
    tick_once(); m_tick(1); cmp("R5 rising edge");
    for (int i = 0; i < 3; i++) step(0, "R5 run");
    // R12 sw trigger ignored in external mode
    wr(2'd3, 8'h01);
    tick_once(); m_tick(0); cmp("R12 sw ignored ext");
    stop_check();
    // falling edge polarity
    wr(2'd1, 8'h0E);
    wr(2'd0, 8'h01);
    clr_irq();
    @(negedge clk); trig_pin = 1'b0;
    repeat (5) @(negedge clk);
    tick_once(); m_tick(1); cmp("R5 falling edge");
    for (int i = 0; i < 3; i++) step(0, "R5 run");
    @(negedge clk); trig_pin = 1'b1;
    repeat (5) @(negedge clk);
    tick_once(); m_tick(0); cmp("R5 wrong polarity ignored");
    stop_check();

    // R11 cutoff
    wr(2'd1, 8'h12);
    @(negedge clk); cut_n = 1'b0;
    @(negedge clk);
    check("R11 cutoff hiz", 32'(pulse_oe), 32'd0);
    cut_n = 1'b1;
    @(negedge clk);
    check("R11 cutoff released", 32'(pulse_oe), 32'd1);
    wr(2'd1, 8'h02);
    cut_n = 1'b0;
    @(negedge clk);
    check("R11 cutoff disabled", 32'(pulse_oe), 32'd1);
    cut_n = 1'b1;

    // random mix: R7 R8 R9 R10
    wr(2'd0, 8'h01);
    clr_irq();
    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom_range(0, 19));
      if (r == 0) set_reload(W'($urandom_range(0, 9)));
      else if (r == 1) clr_irq();
      step(($urandom_range(0, 2) == 0), "R7/R8/R9/R10 random");
    end
    stop_check();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule